// File: doc/BRIEF.md
# Region Hash Walker

The region hash walker checks the integrity of memory regions. Once enabled it reads a contiguous table of region descriptors from memory, one descriptor at a time, and for each region streams a programmed number of data blocks from memory into an external digest engine. When the engine returns the region's digest, the walker does one of two things. In store mode it writes the digest into that region's slot of a separate hash area. In compare mode it reads the reference digest from the same slot and checks it against the new one.

A failed compare sets a sticky per-region status bit. The interrupt line is raised for any status bit whose mask bit is clear. A descriptor can end the list, and can also send the walk back to the first descriptor so that monitoring never stops. When the enable input is dropped, the walker finishes the region it is working on and then returns to idle. All addresses are word addresses. A descriptor takes four consecutive words, and each hash slot holds DIGW words.

Top module: `region_hash_walker`

## Requirements
- R1: After reset, mem_req, dg_valid, dg_start and irq are low and mis_stat is all zero.
- R2: With en high, descriptor i is read at word addresses desc_base+4*i+0..3 in ascending order, and dg_start pulses for one cycle only after all four words of that descriptor have been read.
- R3: Descriptor layout: word 0 holds the region start address; word 1 bit 0 selects compare mode (1) or store mode (0), bit 1 is end-of-list and bit 2 is wrap; word 2 bits [CNTW-1:0] hold a count N; word 3 is ignored. The region sends (N+1)*WPB words from consecutive addresses starting at the start address, in order, with dg_last on the final word only.
- R4: In store mode the digest words 0..DIGW-1 (word k = dg_digest[k*DW +: DW]) are written in ascending order to hash_base+i*DIGW+k.
- R5: In compare mode the walker reads the same slot words and makes no memory write. Any unequal word sets mis_stat[i]. Equal digests leave mis_stat unchanged.
- R6: irq is high while some mis_stat bit is set whose irq_mask bit is 0 (mask bit 1 = masked). Status bits are set whatever the mask.
- R7: Writing 1 to a mis_clr bit clears that status bit. Bits written with 0 keep their value.
- R8: After a region with end-of-list set and wrap clear, the walker makes no further memory or digest traffic until en goes low and then high again. A new run always starts at desc_base.
- R9: After a region with end-of-list and wrap both set, the walk continues at descriptor 0.
- R10: Region NREG-1 ends the list even when its end-of-list bit is clear. Its wrap bit still decides whether the walk continues.
- R11: When en falls during a region, that region completes, including its store or compare, and no further descriptor is fetched.
- R12: A memory request holds mem_req, mem_addr, mem_we and mem_wdata stable until mem_ack. A digest word holds dg_valid, dg_data and dg_last stable until dg_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable |
| desc_base | input | AW | Word address of descriptor 0 |
| hash_base | input | AW | Word address of hash slot 0 |
| irq_mask | input | NREG | Per-region interrupt mask, 1 = masked |
| mis_clr | input | NREG | Write-one-to-clear strobe for mis_stat |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | DW | Read data |
| dg_start | output | 1 | One-cycle pulse: new region digest begins |
| dg_valid | output | 1 | Data word offered to the digest engine |
| dg_data | output | DW | Data word |
| dg_last | output | 1 | Final word of the region |
| dg_ready | input | 1 | Engine accepts the offered word |
| dg_done | input | 1 | Engine presents the finished digest |
| dg_digest | input | DIGW*DW | Finished digest |
| mis_stat | output | NREG | Sticky compare-failure bits |
| irq | output | 1 | Unmasked mismatch interrupt |

## Verification
The bench runs several descriptor tables. One mixes a store region with a compare region whose reference matches, which separates the write path from the read-and-compare path. The same table is then run with a corrupted reference, once unmasked and once masked, so that status behaviour can be told apart from interrupt behaviour. A wrapping table has its enable dropped partway through the second pass, which shows that the walk returns to descriptor 0 and stops only at a region boundary. A four-entry table with no end-of-list bit shows that the last slot ends the list. Memory acknowledgements and engine readiness are stalled in a fixed pattern, so every word of every region is checked for order and for its last flag while the handshakes are being held.

// File: rtl/rhw_pkg.sv
`timescale 1ns/1ps
package rhw_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_START, S_RD, S_PUSH,
      S_WAITD, S_WB, S_CMP, S_NEXT, S_HALT
   } rhw_state_e;

   localparam int unsigned CFG_CMP  = 0;
   localparam int unsigned CFG_EOL  = 1;
   localparam int unsigned CFG_WRAP = 2;
   localparam int unsigned DESC_WORDS = 4;
endpackage

// File: rtl/rhw_ctx.sv
`timescale 1ns/1ps
module rhw_ctx #(
   parameter int AW   = 16,
   parameter int DW   = 32,
   parameter int CNTW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic [1:0]      sel,
   input  logic [DW-1:0]   wdata,
   output logic [AW-1:0]   rg_base,
   output logic            cmp_mode,
   output logic            eol,
   output logic            wrap,
   output logic [CNTW-1:0] nblk
);
   import rhw_pkg::*;

   if (AW > DW)   begin : g_aw_chk   $error("AW must not exceed DW");   end
   if (CNTW > DW) begin : g_cnt_chk  $error("CNTW must not exceed DW"); end

   logic unused_word;
   assign unused_word = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rg_base  <= '0;
         cmp_mode <= 1'b0;
         eol      <= 1'b0;
         wrap     <= 1'b0;
         nblk     <= '0;
      end else if (ld) begin
         case (sel)
            2'd0: rg_base <= wdata[AW-1:0];
            2'd1: begin
               cmp_mode <= wdata[CFG_CMP];
               eol      <= wdata[CFG_EOL];
               wrap     <= wdata[CFG_WRAP];
            end
            2'd2: nblk <= wdata[CNTW-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rhw_walk_cnt.sv
`timescale 1ns/1ps
module rhw_walk_cnt #(
   parameter int AW   = 16,
   parameter int CNTW = 8,
   parameter int WPB  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            step,
   input  logic [CNTW-1:0] blk_max,
   output logic [AW-1:0]   ofs,
   output logic            last
);
   localparam int WW = (WPB > 1) ? $clog2(WPB) : 1;

   if (WPB < 1) begin : g_wpb_chk $error("WPB must be at least 1"); end

   logic [CNTW-1:0] blk;
   logic            wlast;

   if (WPB == 1) begin : g_single
      assign wlast = 1'b1;
   end else begin : g_multi
      logic [WW-1:0] w;
      assign wlast = (w == WW'(WPB - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     w <= '0;
         else if (clr)   w <= '0;
         else if (step)  w <= wlast ? '0 : w + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk <= '0;
         ofs <= '0;
      end else if (clr) begin
         blk <= '0;
         ofs <= '0;
      end else if (step) begin
         ofs <= ofs + 1'b1;
         if (wlast) blk <= blk + 1'b1;
      end
   end

   assign last = wlast && (blk == blk_max);
endmodule

// File: rtl/rhw_flags.sv
`timescale 1ns/1ps
module rhw_flags #(
   parameter int NREG    = 4,
   parameter int IDXW    = 2,
   parameter int IRQ_REG = 0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            set_en,
   input  logic [IDXW-1:0] set_idx,
   input  logic [NREG-1:0] clr,
   input  logic [NREG-1:0] mask,
   output logic [NREG-1:0] stat,
   output logic            irq
);
   logic [NREG-1:0] set_vec;
   logic            pend;

   assign set_vec = set_en ? (NREG'(1) << set_idx) : '0;
   assign pend    = |(stat & ~mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat <= '0;
      else        stat <= (stat & ~clr) | set_vec;
   end

   if (IRQ_REG != 0) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= pend;
      end
   end else begin : g_irq_comb
      assign irq = pend;
   end
endmodule

// File: rtl/region_hash_walker.sv
`timescale 1ns/1ps
module region_hash_walker #(
   parameter int AW      = 16,
   parameter int DW      = 32,
   parameter int NREG    = 4,
   parameter int CNTW    = 8,
   parameter int WPB     = 4,
   parameter int DIGW    = 2,
   parameter int IRQ_REG = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [AW-1:0]       desc_base,
   input  logic [AW-1:0]       hash_base,
   input  logic [NREG-1:0]     irq_mask,
   input  logic [NREG-1:0]     mis_clr,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [DW-1:0]       mem_wdata,
   input  logic                mem_ack,
   input  logic [DW-1:0]       mem_rdata,
   output logic                dg_start,
   output logic                dg_valid,
   output logic [DW-1:0]       dg_data,
   output logic                dg_last,
   input  logic                dg_ready,
   input  logic                dg_done,
   input  logic [DIGW*DW-1:0]  dg_digest,
   output logic [NREG-1:0]     mis_stat,
   output logic                irq
);
   import rhw_pkg::*;

   localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int DCW  = (DIGW > 1) ? $clog2(DIGW) : 1;

   if (NREG < 1 || NREG > 4) begin : g_nreg_chk $error("NREG must be 1 to 4"); end
   if (DIGW < 1)             begin : g_digw_chk $error("DIGW must be at least 1"); end

   rhw_state_e         state;
   logic [IDXW-1:0]    idx;
   logic [1:0]         wcnt;
   logic [DCW-1:0]     dcnt;
   logic [DIGW*DW-1:0] dbuf;
   logic [DW-1:0]      rd_q;
   logic               miss_acc;

   logic [AW-1:0]      rg_base;
   logic               cmp_mode, eol, wrap;
   logic [CNTW-1:0]    nblk;
   logic [AW-1:0]      ofs;
   logic               cnt_last;
   logic [DW-1:0]      dword;
   logic               dlast, miss_now, set_en;

   rhw_ctx #(.AW(AW), .DW(DW), .CNTW(CNTW)) u_ctx (
      .clk(clk), .rst_n(rst_n),
      .ld(state == S_FETCH && mem_ack), .sel(wcnt), .wdata(mem_rdata),
      .rg_base(rg_base), .cmp_mode(cmp_mode), .eol(eol), .wrap(wrap), .nblk(nblk)
   );

   rhw_walk_cnt #(.AW(AW), .CNTW(CNTW), .WPB(WPB)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(state == S_START), .step(state == S_PUSH && dg_ready),
      .blk_max(nblk), .ofs(ofs), .last(cnt_last)
   );

   rhw_flags #(.NREG(NREG), .IDXW(IDXW), .IRQ_REG(IRQ_REG)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .set_en(set_en), .set_idx(idx), .clr(mis_clr), .mask(irq_mask),
      .stat(mis_stat), .irq(irq)
   );

   assign dword    = dbuf[32'(dcnt)*DW +: DW];
   assign dlast    = (dcnt == DCW'(DIGW - 1));
   assign miss_now = miss_acc || (mem_rdata != dword);
   assign set_en   = (state == S_CMP) && mem_ack && dlast && miss_now;

   assign mem_req   = (state == S_FETCH) || (state == S_RD) || (state == S_WB) || (state == S_CMP);
   assign mem_we    = (state == S_WB);
   assign mem_wdata = dword;
   assign dg_start  = (state == S_START);
   assign dg_valid  = (state == S_PUSH);
   assign dg_data   = rd_q;
   assign dg_last   = cnt_last;

   always_comb begin
      case (state)
         S_FETCH:      mem_addr = desc_base + (AW'(idx) << 2) + AW'(wcnt);
         S_RD:         mem_addr = rg_base + ofs;
         S_WB, S_CMP:  mem_addr = hash_base + AW'(idx) * AW'(DIGW) + AW'(dcnt);
         default:      mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         idx      <= '0;
         wcnt     <= '0;
         dcnt     <= '0;
         dbuf     <= '0;
         rd_q     <= '0;
         miss_acc <= 1'b0;
      end else begin
         case (state)
            S_IDLE: if (en) begin
               idx   <= '0;
               wcnt  <= '0;
               state <= S_FETCH;
            end
            S_FETCH: if (mem_ack) begin
               wcnt <= wcnt + 1'b1;
               if (wcnt == 2'(DESC_WORDS - 1)) state <= S_START;
            end
            S_START: state <= S_RD;
            S_RD: if (mem_ack) begin
               rd_q  <= mem_rdata;
               state <= S_PUSH;
            end
            S_PUSH: if (dg_ready) state <= cnt_last ? S_WAITD : S_RD;
            S_WAITD: if (dg_done) begin
               dbuf     <= dg_digest;
               dcnt     <= '0;
               miss_acc <= 1'b0;
               state    <= cmp_mode ? S_CMP : S_WB;
            end
            S_WB: if (mem_ack) begin
               if (dlast) state <= S_NEXT;
               else       dcnt  <= dcnt + 1'b1;
            end
            S_CMP: if (mem_ack) begin
               miss_acc <= miss_now;
               if (dlast) state <= S_NEXT;
               else       dcnt  <= dcnt + 1'b1;
            end
            S_NEXT: begin
               wcnt <= '0;
               if (!en) begin
                  state <= S_IDLE;
               end else if (eol || idx == IDXW'(NREG - 1)) begin
                  if (wrap) begin
                     idx   <= '0;
                     state <= S_FETCH;
                  end else begin
                     state <= S_HALT;
                  end
               end else begin
                  idx   <= idx + 1'b1;
                  state <= S_FETCH;
               end
            end
            S_HALT: if (!en) state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rhw_chk.sv
`timescale 1ns/1ps
module rhw_chk #(
   parameter int AW   = 16,
   parameter int DW   = 32,
   parameter int NREG = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            mem_req,
   input logic            mem_we,
   input logic [AW-1:0]   mem_addr,
   input logic [DW-1:0]   mem_wdata,
   input logic            mem_ack,
   input logic            dg_start,
   input logic            dg_valid,
   input logic [DW-1:0]   dg_data,
   input logic            dg_last,
   input logic            dg_ready,
   input logic [NREG-1:0] mis_stat,
   input logic [NREG-1:0] mis_clr,
   input logic            irq
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R12

   AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dg_valid && !dg_ready |=> dg_valid && $stable(dg_data) && $stable(dg_last)); // R12

   AST_START_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dg_start, dg_valid, mem_req})); // R2

   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      |(mis_stat & ~mis_clr) |=> ((mis_stat & $past(mis_stat & ~mis_clr)) == $past(mis_stat & ~mis_clr))); // R7

   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mis_stat == '0) && ($past(mis_stat) == '0) |-> !irq); // R6
endmodule

bind region_hash_walker rhw_chk #(.AW(AW), .DW(DW), .NREG(NREG)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack), .dg_start(dg_start), .dg_valid(dg_valid), .dg_data(dg_data),
   .dg_last(dg_last), .dg_ready(dg_ready), .mis_stat(mis_stat), .mis_clr(mis_clr),
   .irq(irq)
);

// File: tb/tb_region_hash_walker.sv
`timescale 1ns/1ps
module tb_region_hash_walker;
   localparam int AW = 16, DW = 32, NREG = 4, CNTW = 8, WPB = 4, DIGW = 2;
   localparam logic [AW-1:0] DB = 16'h0000;
   localparam logic [AW-1:0] HB = 16'h0020;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
   logic [NREG-1:0] irq_mask = '0, mis_clr = '0;
   logic mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic dg_ready = 1'b0, dg_done = 1'b0;
   logic [DIGW*DW-1:0] dg_digest = '0;
   logic mem_req, mem_we, dg_start, dg_valid, dg_last, irq;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, dg_data;
   logic [NREG-1:0] mis_stat;

   initial forever #2.5 clk = ~clk;

   region_hash_walker #(.AW(AW), .DW(DW), .NREG(NREG), .CNTW(CNTW), .WPB(WPB), .DIGW(DIGW)) dut (
      .clk(clk), .rst_n(rst_n), .en(en), .desc_base(DB), .hash_base(HB),
      .irq_mask(irq_mask), .mis_clr(mis_clr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .dg_start(dg_start), .dg_valid(dg_valid), .dg_data(dg_data), .dg_last(dg_last),
      .dg_ready(dg_ready), .dg_done(dg_done), .dg_digest(dg_digest),
      .mis_stat(mis_stat), .irq(irq)
   );

   typedef struct { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
   typedef struct { int start; int len; } rg_t;
   wr_t wq[$];
   rg_t rq[$];
   logic [DW-1:0] mem [0:255];

   int n_chk = 0, n_fail = 0, cyc = 0, n_start = 0, desc_rd = 0, n_base_rd = 0, quiet = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // memory model and write monitor
   initial begin : mem_side
      bit pend;
      logic [AW-1:0] pa;
      logic pwe;
      wr_t e;
      pend = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (!mem_req && !dg_valid) quiet++; else quiet = 0;
         if (pend) chk(mem_req && mem_addr == pa && mem_we == pwe, "R12", "request held",
                       {47'd0, mem_req, mem_addr}, {47'd0, 1'b1, pa});
         pend = 1'b0;
         if (mem_ack) begin
            mem_ack = 1'b0;
         end else if (mem_req) begin
            if (cyc % 3 == 0) begin
               pend = 1'b1; pa = mem_addr; pwe = mem_we;
            end else begin
               mem_ack = 1'b1;
               if (mem_we) begin
                  if (wq.size() == 0) begin
                     chk(1'b0, "R5", "unexpected write", {16'd0, mem_addr, mem_wdata}, 64'd0);
                  end else begin
                     e = wq.pop_front();
                     chk(e.a == mem_addr && e.d == mem_wdata, "R4", "hash write",
                         {16'd0, mem_addr, mem_wdata}, {16'd0, e.a, e.d});
                  end
                  mem[mem_addr[7:0]] = mem_wdata;
               end else begin
                  mem_rdata = mem[mem_addr[7:0]];
                  if (mem_addr < DB + 16) desc_rd++;
                  if (mem_addr == DB) n_base_rd++;
               end
            end
         end
      end
   end

   // digest engine stub and stream monitor
   initial begin : eng_side
      int beats, cd;
      logic [DW-1:0] s, x;
      rg_t cur;
      beats = 0; cd = 0; s = '0; x = '0; cur.start = 0; cur.len = 0;
      forever begin
         @(negedge clk);
         dg_done = 1'b0;
         if (dg_start) begin
            n_start++;
            chk(desc_rd == 4, "R2", "descriptor words before start", 64'(desc_rd), 64'd4);
            desc_rd = 0; beats = 0; s = '0; x = '0;
            if (rq.size() == 0) begin
               chk(1'b0, "R8", "unexpected region start", 64'd1, 64'd0);
               cur.start = 0; cur.len = 0;
            end else cur = rq.pop_front();
         end
         dg_ready = (cyc % 4) != 1;
         if (dg_valid && dg_ready) begin
            chk(dg_data == mem[(cur.start + beats) & 255], "R3", "word data",
                64'(dg_data), 64'(mem[(cur.start + beats) & 255]));
            chk(dg_last == (beats == cur.len - 1), "R3", "last flag",
                64'(dg_last), 64'(beats == cur.len - 1));
            s = s + dg_data; x = x ^ dg_data; beats++;
            if (dg_last) cd = 3;
         end else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
               dg_done = 1'b1;
               dg_digest = {x ^ DW'(beats), s};
            end
         end
      end
   end

   function automatic logic [DW-1:0] dsum(input int st, input int len);
      logic [DW-1:0] r = '0;
      for (int k = 0; k < len; k++) r = r + mem[(st + k) & 255];
      return r;
   endfunction

   function automatic logic [DW-1:0] dxor(input int st, input int len);
      logic [DW-1:0] r = '0;
      for (int k = 0; k < len; k++) r = r ^ mem[(st + k) & 255];
      return r ^ DW'(len);
   endfunction

   task automatic put_desc(input int i, input int st, input bit cmp, input bit eol,
                           input bit wrap, input int n);
      mem[4*i]     = DW'(st);
      mem[4*i + 1] = {29'd0, wrap, eol, cmp};
      mem[4*i + 2] = DW'(n);
      mem[4*i + 3] = 32'hdead_0000 | DW'(i);
   endtask

   task automatic plan_region(input int i, input int st, input int n, input bit cmp, input bit bad);
      rg_t r;
      wr_t w;
      int len;
      len = (n + 1) * WPB;
      r.start = st; r.len = len;
      rq.push_back(r);
      if (cmp) begin
         mem[HB + 2*i]     = dsum(st, len) ^ DW'(bad);
         mem[HB + 2*i + 1] = dxor(st, len);
      end else begin
         w.a = HB + AW'(2*i);     w.d = dsum(st, len); wq.push_back(w);
         w.a = HB + AW'(2*i + 1); w.d = dxor(st, len); wq.push_back(w);
      end
   endtask

   task automatic run_list();
      en = 1'b1;
      while (!mem_req) @(negedge clk);
      chk(mem_addr == DB, "R8", "run starts at first descriptor", 64'(mem_addr), 64'(DB));
      while (quiet < 40) @(negedge clk);
   endtask

   task automatic stop_run();
      en = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(negedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int base, nb;
      for (int k = 0; k < 256; k++) mem[k] = (DW'(k) * 32'h9e3779b1) ^ 32'h0bad_f00d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!mem_req && !dg_valid && !dg_start, "R1", "idle outputs", {mem_req, dg_valid, dg_start}, 0);
      chk(!irq && mis_stat == '0, "R1", "status clear", {irq, mis_stat}, 0);

      // store region then matching compare region, end of list
      put_desc(0, 'h40, 0, 0, 0, 1);
      put_desc(1, 'h60, 1, 1, 0, 0);
      plan_region(0, 'h40, 1, 0, 0);
      plan_region(1, 'h60, 0, 1, 0);
      base = n_start;
      run_list();
      chk(n_start - base == 2, "R8", "regions before stop", 64'(n_start - base), 2);
      chk(wq.size() == 0, "R4", "all hash writes seen", 64'(wq.size()), 0);
      chk(rq.size() == 0, "R3", "all regions streamed", 64'(rq.size()), 0);
      chk(mem[HB] == dsum('h40, 8), "R4", "slot 0 word 0", 64'(mem[HB]), 64'(dsum('h40, 8)));
      chk(mis_stat == '0, "R5", "equal compare leaves status", 64'(mis_stat), 0);
      chk(!irq, "R6", "no irq without mismatch", 64'(irq), 0);
      repeat (30) @(negedge clk);
      chk(n_start - base == 2 && !mem_req, "R8", "stays stopped", 64'(n_start - base), 2);
      stop_run();

      // corrupted reference, unmasked
      plan_region(0, 'h40, 1, 0, 0);
      plan_region(1, 'h60, 0, 1, 1);
      run_list();
      chk(mis_stat == 4'b0010, "R5", "mismatch sets region bit", 64'(mis_stat), 64'b0010);
      chk(irq, "R6", "unmasked irq", 64'(irq), 1);
      mis_clr = 4'b0001; @(negedge clk); mis_clr = '0;
      chk(mis_stat == 4'b0010, "R7", "zero bits keep status", 64'(mis_stat), 64'b0010);
      mis_clr = 4'b0010; @(negedge clk); mis_clr = '0;
      chk(mis_stat == '0, "R7", "one clears status", 64'(mis_stat), 0);
      chk(!irq, "R7", "irq drops after clear", 64'(irq), 0);
      stop_run();

      // corrupted reference, masked
      irq_mask = 4'b0010;
      plan_region(0, 'h40, 1, 0, 0);
      plan_region(1, 'h60, 0, 1, 1);
      run_list();
      chk(mis_stat == 4'b0010, "R6", "status set while masked", 64'(mis_stat), 64'b0010);
      chk(!irq, "R6", "masked irq stays low", 64'(irq), 0);
      irq_mask = '0; @(negedge clk);
      chk(irq, "R6", "unmask raises irq", 64'(irq), 1);
      mis_clr = 4'b1111; @(negedge clk); mis_clr = '0;
      stop_run();

      // wrap, enable dropped in second pass
      put_desc(1, 'h60, 1, 1, 1, 0);
      plan_region(0, 'h40, 1, 0, 0);
      plan_region(1, 'h60, 0, 1, 0);
      plan_region(0, 'h40, 1, 0, 0);
      base = n_start; nb = n_base_rd;
      en = 1'b1;
      while (n_start < base + 3) @(negedge clk);
      en = 1'b0;
      while (quiet < 40) @(negedge clk);
      chk(n_start - base == 3, "R11", "no fetch after enable drop", 64'(n_start - base), 3);
      chk(wq.size() == 0, "R11", "current region stored", 64'(wq.size()), 0);
      chk(n_base_rd - nb == 2, "R9", "descriptor 0 fetched again", 64'(n_base_rd - nb), 2);
      chk(rq.size() == 0 && mis_stat == '0, "R9", "wrapped pass matched", 64'(rq.size()), 0);
      repeat (5) @(negedge clk);

      // four regions, no end-of-list bit
      put_desc(0, 'h40, 0, 0, 0, 0);
      put_desc(1, 'h50, 0, 0, 0, 0);
      put_desc(2, 'h60, 0, 0, 0, 0);
      put_desc(3, 'h70, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) plan_region(i, 'h40 + 16*i, 0, 0, 0);
      base = n_start;
      run_list();
      chk(n_start - base == 4, "R10", "last slot ends list", 64'(n_start - base), 4);
      chk(wq.size() == 0, "R10", "all four slots stored", 64'(wq.size()), 0);
      chk(mem[HB + 6] == dsum('h70, 4), "R10", "slot 3 word 0", 64'(mem[HB + 6]), 64'(dsum('h70, 4)));
      stop_run();

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule